// File: doc/BRIEF.md
# Serial Port Host Register File

This block is the processor-facing register set of a classic byte-oriented serial port. A host reaches it over a small parallel bus: a 3-bit register offset, one byte of write data, one byte of read data, and separate read and write strobes that each last one clock. Behind the bus sit the interrupt-enable, line-control, modem-control, scratch and FIFO-control registers, the two divisor latch bytes, a single receive holding byte, and the derived line-status and interrupt-identification values.

Received bytes arrive on a one-cycle valid/byte input and land in the holding byte. Bytes the host writes to the transmit offset leave on a one-cycle valid/byte output unless loopback is on. A level interrupt output is high whenever the interrupt-identification value reports a pending cause. Read data is combinational from the current state. Every side effect of a read or write (clearing status, clearing the interrupt cause, loading a register) takes place at the clock edge that ends the strobe cycle.

Top module: `serial_regfile`

## Requirements
- R1: After reset, line status reads 0x60 (bit 5 transmit-holding-empty and bit 6 transmitter-empty set, all else clear), interrupt identification reads 0x01, interrupt enable, line control, modem control, scratch and both divisor bytes read 0x00, irq is low and tx_valid is low.
- R2: While line-control bit 7 is set, offset 0 reads and writes the low divisor byte and offset 1 the high divisor byte, with no receive-clear or transmit side effect. Offsets 2 to 7 behave exactly as with bit 7 clear.
- R3: A write to the interrupt-enable register (offset 1, divisor access off) keeps only data bits 5:0; bits 7:6 always read back as zero.
- R4: Writes to offset 5 (line status) and offset 6 (modem status, which always reads 0x00) change no state.
- R5: A rx_valid cycle loads rx_byte into the holding byte and sets the data-ready bit (line-status bit 0). If data-ready was already set and the same cycle is not an offset-0 data read, the overrun bit (line-status bit 1) is set as well and the new byte replaces the old one.
- R6: A read at offset 0 with divisor access off returns the holding byte, then clears data-ready and forces identification to 0x01, unless rx_valid is high in the same cycle, in which case data-ready stays set.
- R7: A read at offset 5 returns the current line status and afterwards clears bits 4:1, unless a new overrun is raised in the same cycle.
- R8: At each edge that carries rx_valid, a read or a write, and no clearing event of R6 or R9, identification becomes 0x04 if enable bit 0 and data-ready are both set after the edge, otherwise 0x02 if enable bit 1 is set, otherwise 0x01. At edges with none of these events it holds its value.
- R9: A write at offset 0 with divisor access off forces identification to 0x01. One cycle later tx_valid pulses for one cycle with tx_byte equal to the written byte, unless modem-control bit 4 (loopback) is set, in which case tx_valid stays low.
- R10: A read at offset 2 returns the identification value with bits 7:6 set when FIFO-control bit 0 was last written as 1.
- R11: Line control (offset 3), modem control (offset 4) and scratch (offset 7) read back the last value written.
- R12: irq is high exactly when the identification value differs from 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, combinational from current state |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte present, one-cycle pulse |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted data-ready or overrun flag appears in the line status on the very next read of offset 5, and a stale ready flag also shows on irq at the first later edge that recomputes the identification value. A wrong identification value is visible on irq in the cycle after the edge that set it. A wrong divisor-access bit reroutes offsets 0 and 1, so the next read returns the wrong register, and a missed transmit side effect shows as a missing or extra tx_valid pulse one cycle after the write. The bench drives one bus access, received byte or idle per cycle and compares irq, tx_valid, tx_byte and the read data with a behavioural model on every clock.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 3;

    localparam logic [AW-1:0] OFF_DATA    = 3'd0;
    localparam logic [AW-1:0] OFF_IEN     = 3'd1;
    localparam logic [AW-1:0] OFF_IID     = 3'd2;
    localparam logic [AW-1:0] OFF_LCTL    = 3'd3;
    localparam logic [AW-1:0] OFF_MCTL    = 3'd4;
    localparam logic [AW-1:0] OFF_LSTAT   = 3'd5;
    localparam logic [AW-1:0] OFF_MSTAT   = 3'd6;
    localparam logic [AW-1:0] OFF_SCRATCH = 3'd7;

    localparam int unsigned LS_READY   = 0;
    localparam int unsigned LS_OVERRUN = 1;
    localparam int unsigned LS_TXHOLD  = 5;
    localparam int unsigned LS_TXIDLE  = 6;
    localparam int unsigned LC_DIVACC  = 7;
    localparam int unsigned MC_LOOP    = 4;
    localparam int unsigned IE_RX      = 0;
    localparam int unsigned IE_TX      = 1;
    localparam int unsigned IE_KEEP    = 6;
    localparam int unsigned FC_FIFO    = 0;

    typedef enum logic [DW-1:0] {
        IID_NONE = 8'h01,
        IID_TXE  = 8'h02,
        IID_RXD  = 8'h04
    } iid_e;

    typedef struct packed {
        logic thr_wr;
        logic dll_wr;
        logic dlm_wr;
        logic ier_wr;
        logic fcr_wr;
        logic lcr_wr;
        logic mcr_wr;
        logic scr_wr;
        logic rbr_rd;
        logic lsr_rd;
        logic access;
    } strobe_t;

    function automatic iid_e iid_pick(input logic [DW-1:0] ier, input logic ready);
        if (ier[IE_RX] && ready)
            return IID_RXD;
        else if (ier[IE_TX])
            return IID_TXE;
        else
            return IID_NONE;
    endfunction

endpackage

// File: rtl/sr_bus_decode.sv
module sr_bus_decode
    import uart_regs_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic          divacc,
    output strobe_t       st
);
    always_comb begin
        st        = '0;
        st.access = rd | wr;
        if (wr) begin
            unique case (addr)
                OFF_DATA:    if (divacc) st.dll_wr = 1'b1; else st.thr_wr = 1'b1;
                OFF_IEN:     if (divacc) st.dlm_wr = 1'b1; else st.ier_wr = 1'b1;
                OFF_IID:     st.fcr_wr = 1'b1;
                OFF_LCTL:    st.lcr_wr = 1'b1;
                OFF_MCTL:    st.mcr_wr = 1'b1;
                OFF_SCRATCH: st.scr_wr = 1'b1;
                default:     ;
            endcase
        end
        if (rd) begin
            st.rbr_rd = (addr == OFF_DATA) && !divacc;
            st.lsr_rd = (addr == OFF_LSTAT);
        end
    end
endmodule

// File: rtl/sr_rx_hold.sv
module sr_rx_hold
    import uart_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rbr_rd,
    input  logic          lsr_rd,
    output logic [DW-1:0] hold_q,
    output logic          ready_q,
    output logic          overrun_q,
    output logic          ready_next
);
    logic overrun_next;

    always_comb begin
        ready_next = ready_q;
        if (rbr_rd)
            ready_next = 1'b0;
        if (rx_valid)
            ready_next = 1'b1;

        overrun_next = overrun_q;
        if (lsr_rd)
            overrun_next = 1'b0;
        if (rx_valid && ready_q && !rbr_rd)
            overrun_next = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            ready_q   <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            if (rx_valid)
                hold_q <= rx_byte;
            ready_q   <= ready_next;
            overrun_q <= overrun_next;
        end
    end
endmodule

// File: rtl/sr_intr.sv
module sr_intr
    import uart_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reeval,
    input  logic          quiet,
    input  logic [DW-1:0] ier_next,
    input  logic          ready_next,
    output iid_e          iid_q,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst)
            iid_q <= IID_NONE;
        else if (quiet)
            iid_q <= IID_NONE;
        else if (reeval)
            iid_q <= iid_pick(ier_next, ready_next);
    end

    assign irq = (iid_q != IID_NONE);
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
    import uart_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    output logic          irq
);
    localparam logic [DW-1:0] IE_MASK = DW'((1 << IE_KEEP) - 1);

    strobe_t       st;
    logic [DW-1:0] ier_q, lcr_q, mcr_q, scr_q, dll_q, dlm_q;
    logic          fifo_en_q;
    logic [DW-1:0] ier_next;
    logic [DW-1:0] hold_q;
    logic          ready_q, overrun_q, ready_next;
    iid_e          iid_q;
    logic          divacc, loop_on;
    logic [DW-1:0] lsr_val, iid_val;

    assign divacc  = lcr_q[LC_DIVACC];
    assign loop_on = mcr_q[MC_LOOP];

    sr_bus_decode u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .divacc (divacc),
        .st     (st)
    );

    sr_rx_hold u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rbr_rd     (st.rbr_rd),
        .lsr_rd     (st.lsr_rd),
        .hold_q     (hold_q),
        .ready_q    (ready_q),
        .overrun_q  (overrun_q),
        .ready_next (ready_next)
    );

    assign ier_next = st.ier_wr ? (bus_wdata & IE_MASK) : ier_q;

    sr_intr u_int (
        .clk        (clk),
        .rst        (rst),
        .reeval     (st.access | rx_valid),
        .quiet      (st.thr_wr | st.rbr_rd),
        .ier_next   (ier_next),
        .ready_next (ready_next),
        .iid_q      (iid_q),
        .irq        (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q     <= '0;
            lcr_q     <= '0;
            mcr_q     <= '0;
            scr_q     <= '0;
            dll_q     <= '0;
            dlm_q     <= '0;
            fifo_en_q <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
        end else begin
            ier_q <= ier_next;
            if (st.lcr_wr) lcr_q <= bus_wdata;
            if (st.mcr_wr) mcr_q <= bus_wdata;
            if (st.scr_wr) scr_q <= bus_wdata;
            if (st.dll_wr) dll_q <= bus_wdata;
            if (st.dlm_wr) dlm_q <= bus_wdata;
            if (st.fcr_wr) fifo_en_q <= bus_wdata[FC_FIFO];
            tx_valid <= st.thr_wr && !loop_on;
            if (st.thr_wr) tx_byte <= bus_wdata;
        end
    end

    always_comb begin
        lsr_val             = '0;
        lsr_val[LS_READY]   = ready_q;
        lsr_val[LS_OVERRUN] = overrun_q;
        lsr_val[LS_TXHOLD]  = 1'b1;
        lsr_val[LS_TXIDLE]  = 1'b1;

        iid_val = iid_q;
        if (fifo_en_q)
            iid_val[DW-1:DW-2] = 2'b11;
    end

    always_comb begin
        unique case (bus_addr)
            OFF_DATA:    bus_rdata = divacc ? dll_q : hold_q;
            OFF_IEN:     bus_rdata = divacc ? dlm_q : ier_q;
            OFF_IID:     bus_rdata = iid_val;
            OFF_LCTL:    bus_rdata = lcr_q;
            OFF_MCTL:    bus_rdata = mcr_q;
            OFF_LSTAT:   bus_rdata = lsr_val;
            OFF_MSTAT:   bus_rdata = '0;
            OFF_SCRATCH: bus_rdata = scr_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sr_regfile_checker.sv
module sr_regfile_checker
    import uart_regs_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic          rx_valid,
    input logic          tx_valid,
    input logic [DW-1:0] tx_byte,
    input logic          irq,
    input logic          divacc,
    input logic          loop_on,
    input logic          fifo_en,
    input logic          ready,
    input logic          overrun
);
    logic data_wr, data_rd;
    assign data_wr = bus_wr && (bus_addr == OFF_DATA) && !divacc;
    assign data_rd = bus_rd && (bus_addr == OFF_DATA) && !divacc;

    assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !loop_on) |=> (tx_valid && tx_byte == $past(bus_wdata)));

    assert_loop_silent_R9: assert property (@(posedge clk) disable iff (rst)
        !(data_wr && !loop_on) |=> !tx_valid);

    assert_write_quiets_irq_R9: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> !irq);

    assert_read_quiets_irq_R6: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> !irq);

    assert_overrun_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ready && !data_rd) |=> overrun);

    assert_status_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_LSTAT && !rx_valid) |=> !overrun);

    assert_divisor_no_side_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_DATA && divacc && !rx_valid) |=> (ready == $past(ready)));

    assert_fifo_bits_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_IID) |-> (bus_rdata[DW-1:DW-2] == {2{fifo_en}}));

    assert_ien_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_IEN && !divacc) |-> (bus_rdata[DW-1:DW-2] == 2'b00));
endmodule

bind serial_regfile sr_regfile_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .irq       (irq),
    .divacc    (divacc),
    .loop_on   (loop_on),
    .fifo_en   (fifo_en_q),
    .ready     (ready_q),
    .overrun   (overrun_q)
);

// File: tb/serial_regfile_bench.sv
`timescale 1ns/1ps
module serial_regfile_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       irq;

    always #10 clk = ~clk;

    serial_regfile u_serial_regfile (
        .clk (clk), .rst (rst),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
        .bus_rd (bus_rd), .bus_rdata (bus_rdata),
        .rx_valid (rx_valid), .rx_byte (rx_byte),
        .tx_valid (tx_valid), .tx_byte (tx_byte), .irq (irq)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string req = "R1";

    // behavioural reference state
    int m_ier, m_lcr, m_mcr, m_scr, m_dll, m_dlm, m_fifo;
    int m_hold, m_ready, m_ovr, m_iid, m_txv, m_txb;

    function automatic int exp_read(int a);
        int dl = (m_lcr >> 7) & 1;
        case (a)
            0: return dl ? m_dll : m_hold;
            1: return dl ? m_dlm : m_ier;
            2: return m_iid | (m_fifo ? 8'hC0 : 0);
            3: return m_lcr;
            4: return m_mcr;
            5: return 8'h60 | (m_ovr << 1) | m_ready;
            6: return 0;
            default: return m_scr;
        endcase
    endfunction

    task automatic check(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0; m_dll = 0; m_dlm = 0; m_fifo = 0;
        m_hold = 0; m_ready = 0; m_ovr = 0; m_iid = 1; m_txv = 0; m_txb = 0;
    endtask

    task automatic model_step(int rd, int wr, int a, int wd, int rv, int rb);
        int dl    = (m_lcr >> 7) & 1;
        int thr   = wr && a == 0 && !dl;
        int rbr   = rd && a == 0 && !dl;
        int n_rdy = m_ready;
        int n_ovr = m_ovr;
        if (rd && a == 5) n_ovr = 0;
        if (rv && m_ready && !rbr) n_ovr = 1;
        if (rbr) n_rdy = 0;
        if (rv) begin n_rdy = 1; m_hold = rb; end
        if (wr) begin
            case (a)
                0: if (dl) m_dll = wd;
                1: if (dl) m_dlm = wd; else m_ier = wd & 8'h3F;
                2: m_fifo = wd & 1;
                3: m_lcr = wd;
                4: m_mcr = wd;
                7: m_scr = wd;
                default: ;
            endcase
        end
        m_ready = n_rdy;
        m_ovr   = n_ovr;
        if (thr || rbr)
            m_iid = 1;
        else if (rd || wr || rv)
            m_iid = ((m_ier & 1) && m_ready) ? 4 : ((m_ier & 2) ? 2 : 1);
        m_txv = thr && !((m_mcr >> 4) & 1);
        if (thr) m_txb = wd;
    endtask

    // one clock: drive, compare before the edge, advance the model
    task automatic step(int rd, int wr, int a, int wd, int rv, int rb);
        bus_rd = rd[0]; bus_wr = wr[0]; bus_addr = a[2:0]; bus_wdata = wd[7:0];
        rx_valid = rv[0]; rx_byte = rb[7:0];
        #2;
        check("irq", int'(irq), (m_iid != 1) ? 1 : 0);   // R12
        check("tx_valid", int'(tx_valid), m_txv);
        if (m_txv) check("tx_byte", int'(tx_byte), m_txb);
        if (rd) check("rdata", int'(bus_rdata), exp_read(a));
        @(posedge clk);
        model_step(rd, wr, a, wd, rv, rb);
        @(negedge clk);
    endtask

    task automatic wr_reg(int a, int d); step(0, 1, a, d, 0, 0); endtask
    task automatic rd_reg(int a);        step(1, 0, a, 0, 0, 0); endtask
    task automatic rx(int b);            step(0, 0, 0, 0, 1, b); endtask
    task automatic idle();               step(0, 0, 0, 0, 0, 0); endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        req = "R1";
        for (int a = 0; a < 8; a++) rd_reg(a);
        idle();

        req = "R11";
        wr_reg(7, 8'h5A); wr_reg(3, 8'h03); wr_reg(4, 8'h0B);
        rd_reg(7); rd_reg(3); rd_reg(4);

        req = "R3";
        wr_reg(1, 8'hFF); rd_reg(1); idle();
        req = "R8";
        rd_reg(2); wr_reg(1, 8'h00); idle(); rd_reg(2);

        req = "R4";
        wr_reg(5, 8'hFF); wr_reg(6, 8'hA5); rd_reg(5); rd_reg(6); rd_reg(2);

        req = "R5";
        wr_reg(1, 8'h01); rx(8'h41); idle();
        req = "R8";
        rd_reg(2);
        req = "R6";
        rd_reg(0); idle(); rd_reg(5);

        req = "R5";
        rx(8'h10); rx(8'h20); idle();
        req = "R7";
        rd_reg(5); rd_reg(5);
        req = "R6";
        rd_reg(0); rd_reg(5);

        req = "R5";
        rx(8'h30);
        step(1, 0, 0, 0, 1, 8'h31);   // read and new byte together
        rd_reg(5); rd_reg(2); rd_reg(0);
        step(1, 0, 5, 0, 1, 8'h32);   // status read while new byte lands
        rx(8'h33); rd_reg(5); rd_reg(0);

        req = "R2";
        wr_reg(3, 8'h83); wr_reg(0, 8'h12); wr_reg(1, 8'h34);
        rd_reg(0); rd_reg(1); rd_reg(3); rd_reg(2); rd_reg(7);
        rx(8'h55); rd_reg(0); rd_reg(5);
        wr_reg(3, 8'h03); rd_reg(0); rd_reg(1); rd_reg(5);

        req = "R9";
        wr_reg(1, 8'h02); idle();
        wr_reg(0, 8'hC3); idle(); idle(); rd_reg(2); idle();
        wr_reg(0, 8'h7E); wr_reg(0, 8'h81); idle();
        wr_reg(4, 8'h10); wr_reg(0, 8'h99); idle(); rd_reg(4);
        wr_reg(4, 8'h00); wr_reg(0, 8'h66); idle();

        req = "R10";
        rd_reg(2); wr_reg(2, 8'h01); rd_reg(2); wr_reg(2, 8'h00); rd_reg(2);

        req = "R12";
        wr_reg(1, 8'h03); rx(8'hEE); idle(); rd_reg(2); rd_reg(0); idle();
        wr_reg(1, 8'h00); idle(); rd_reg(2);

        req = "R1";
        rst = 1'b1; @(posedge clk); model_reset(); @(negedge clk); rst = 1'b0;
        for (int a = 0; a < 8; a++) rd_reg(a);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule